// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block carries out arithmetic shifts, logical shifts, plain rotates and rotates through an extend bit. Each can go left or right, on 8, 16 or 32 bit operands. It moves the operand by one bit position per step. Every step costs two clocks, and a fixed setup cost depends on the operand size. The unit therefore takes a known, count-dependent number of clocks, which a cycle-faithful processor model can rely on. A pipeline controller pulses `start` with the operation fields, the operand, a 6-bit count and the incoming extend bit. After the documented latency, the unit pulses `done` together with the result, the five condition flags and the number of clocks it spent.

A second, fixed-time form serves operands held in memory. It accepts only byte and word sizes. It always moves by exactly one bit, whatever the count input holds, and always takes 8 clocks. A memory-form request at long size is illegal, and the unit refuses it.

Top module: `bitstep_shifter`

## Requirements
- R1: For the register form, `done` rises exactly 6+2n clock edges after the edge that accepts `start` for byte and word operands, and 8+2n edges after it for long operands. Here n is the 6-bit `count` (0 to 63). `cycles` shows that same number while `done` is high.
- R2: A count of 0 returns the operand unchanged, masked to its size, and still spends the base 6 or 8 clocks.
- R3: `op_kind` 0 is arithmetic and 1 is logical, with `dir_left` 1 meaning left. A left shift fills bit 0 with zero. A right logical shift fills the top bit of the size with zero, and a right arithmetic shift copies the top bit into it. `size` 0 is byte, 1 is word, and 2 or 3 is long. Result bits above the size are always zero.
- R4: `op_kind` 2 is a rotate within the size. `op_kind` 3 rotates through a chain of size+1 bits, in which the extend bit sits beyond the top bit on the left and below bit 0 on the right.
- R5: The carry flag C holds the last bit moved out. With a zero count, C is 0, except for `op_kind` 3, where C equals the extend value. The extend flag X follows C for `op_kind` 0, 1 and 3. For `op_kind` 2, X keeps `x_in`.
- R6: The overflow flag V is set only for an arithmetic left shift in which the top bit of the size changes at any step. N is the top bit of the result within the size, and Z is set when the result is zero within the size.
- R7: With `mem_form` 1 at byte or word size, the unit moves the operand by exactly one bit and ignores `count`. It finishes in 8 clocks, with `cycles` = 8.
- R8: A `mem_form` request at long size is refused. The unit does not become busy, `done` does not pulse, and the outputs keep their previous values.
- R9: A `start` pulse that arrives while an operation is running is ignored. The running operation completes with its own result and its own latency.
- R10: `done` is a single-cycle pulse. The result, flags and `cycles` stay unchanged until the next `done`.
- R11: After reset, `done`, `result`, `cycles` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| mem_form | input | 1 | Selects the fixed one-bit memory form |
| op_kind | input | 2 | 0 arithmetic, 1 logical, 2 rotate, 3 rotate through extend |
| dir_left | input | 1 | 1 left, 0 right |
| size | input | 2 | 0 byte, 1 word, 2/3 long |
| operand | input | 32 | Value to be shifted |
| count | input | 6 | Bit count for the register form |
| x_in | input | 1 | Incoming extend flag |
| result | output | 32 | Shifted value, zero above the size |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 8 | Clocks spent by the finished operation |

## Verification
On every cycle, the assertions check four things. First, each completion arrives exactly as many clocks after its accepted start as `cycles` reports. Second, `done` never lasts two cycles. Third, a refused long memory request leaves the unit idle. Fourth, several flag and width rules hold: byte results are clean above bit 7, V appears only for arithmetic shifts, and plain rotates keep X. The correctness of each result bit, of C, N and Z, and of the exact latency formula shows up only in the bench. The bench sweeps every size, operation and direction over counts 0 to 63 against its reference model, and runs directed cases for the memory form, starts while busy, and reset.

// File: rtl/bitstep_pkg.sv
package bitstep_pkg;
  localparam int LANE_W = 32;

  typedef enum logic [1:0] {
    OPK_ARITH = 2'd0,
    OPK_LOGIC = 2'd1,
    OPK_ROT   = 2'd2,
    OPK_ROTX  = 2'd3
  } opk_t;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_WORD     = 2'd1,
    SZ_LONG     = 2'd2,
    SZ_LONG_ALT = 2'd3
  } size_t;

  function automatic logic [4:0] msb_pos(size_t s);
    case (s)
      SZ_BYTE: msb_pos = 5'd7;
      SZ_WORD: msb_pos = 5'd15;
      default: msb_pos = 5'd31;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] lane_mask(size_t s);
    case (s)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_WORD: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic is_long(size_t s);
    is_long = s[1];
  endfunction
endpackage

// File: rtl/bitstep_latency.sv
module bitstep_latency
  import bitstep_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8,
  parameter int MEM_CYC    = 8,
  parameter int CYC_W      = 8
) (
  input  size_t             sz,
  input  logic              mem,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CYC_W-1:0]  total,
  output logic [CNT_W-1:0]  steps,
  output logic              legal
);
  always_comb begin
    legal = !(mem && is_long(sz));
    if (mem) begin
      steps = CNT_W'(1);
      total = CYC_W'(MEM_CYC);
    end else begin
      steps = cnt;
      total = (is_long(sz) ? CYC_W'(BASE_LONG) : CYC_W'(BASE_SHORT))
              + (CYC_W'(cnt) << 1);
    end
  end
endmodule

// File: rtl/bitstep_onebit.sv
module bitstep_onebit
  import bitstep_pkg::*;
(
  input  logic [LANE_W-1:0] val,
  input  size_t             sz,
  input  opk_t              opk,
  input  logic              left,
  input  logic              xin,
  output logic [LANE_W-1:0] nxt,
  output logic              outbit,
  output logic              msb_flip
);
  logic [4:0]        m;
  logic [LANE_W-1:0] mask;
  logic              top, bot, fill;

  always_comb begin
    m        = msb_pos(sz);
    mask     = lane_mask(sz);
    top      = val[m];
    bot      = val[0];
    msb_flip = val[m] ^ val[m - 5'd1];
    if (left) begin
      outbit = top;
      case (opk)
        OPK_ROT:  fill = top;
        OPK_ROTX: fill = xin;
        default:  fill = 1'b0;
      endcase
      nxt = ((val << 1) & mask) | {{(LANE_W-1){1'b0}}, fill};
    end else begin
      outbit = bot;
      case (opk)
        OPK_ARITH: fill = top;
        OPK_ROT:   fill = bot;
        OPK_ROTX:  fill = xin;
        default:   fill = 1'b0;
      endcase
      nxt = (val >> 1) | ({{(LANE_W-1){1'b0}}, fill} << m);
    end
  end
endmodule

// File: rtl/bitstep_shifter.sv
module bitstep_shifter
  import bitstep_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8,
  parameter int MEM_CYC    = 8,
  localparam int MAX_CYC   = BASE_LONG + 2 * ((1 << CNT_W) - 1),
  localparam int CYC_W     = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mem_form,
  input  logic [1:0]        op_kind,
  input  logic              dir_left,
  input  logic [1:0]        size,
  input  logic [LANE_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic              x_in,
  output logic [LANE_W-1:0] result,
  output logic              flag_x,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              done,
  output logic [CYC_W-1:0]  cycles
);
  size_t             sz_in, sz_q;
  opk_t              opk_in, opk_q;
  logic              left_q, busy, legal;
  logic [LANE_W-1:0] val_q, val_nxt;
  logic [CNT_W-1:0]  steps_in, steps_q;
  logic [CYC_W-1:0]  total_in, total_q, elapsed;
  logic              xq, cq, vq, outbit, msb_flip, accept, step_now;

  assign sz_in    = size_t'(size);
  assign opk_in   = opk_t'(op_kind);
  assign accept   = start && !busy && legal;
  assign step_now = busy && (steps_q != '0) && elapsed[0];

  bitstep_latency #(
    .CNT_W(CNT_W), .BASE_SHORT(BASE_SHORT), .BASE_LONG(BASE_LONG),
    .MEM_CYC(MEM_CYC), .CYC_W(CYC_W)
  ) u_lat (
    .sz(sz_in), .mem(mem_form), .cnt(count),
    .total(total_in), .steps(steps_in), .legal(legal)
  );

  bitstep_onebit u_step (
    .val(val_q), .sz(sz_q), .opk(opk_q), .left(left_q), .xin(xq),
    .nxt(val_nxt), .outbit(outbit), .msb_flip(msb_flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      val_q   <= '0;
      sz_q    <= SZ_BYTE;
      opk_q   <= OPK_ARITH;
      left_q  <= 1'b0;
      steps_q <= '0;
      total_q <= '0;
      elapsed <= '0;
      xq      <= 1'b0;
      cq      <= 1'b0;
      vq      <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      cycles  <= '0;
      flag_x  <= 1'b0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_c  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        val_q   <= operand & lane_mask(sz_in);
        sz_q    <= sz_in;
        opk_q   <= opk_in;
        left_q  <= dir_left;
        steps_q <= steps_in;
        total_q <= total_in;
        elapsed <= CYC_W'(1);
        xq      <= x_in;
        cq      <= (opk_in == OPK_ROTX) ? x_in : 1'b0;
        vq      <= 1'b0;
      end else if (busy) begin
        elapsed <= elapsed + CYC_W'(1);
        if (step_now) begin
          val_q   <= val_nxt;
          steps_q <= steps_q - CNT_W'(1);
          cq      <= outbit;
          if (opk_q != OPK_ROT) xq <= outbit;
          if (opk_q == OPK_ARITH && left_q && msb_flip) vq <= 1'b1;
        end
        if (elapsed == total_q) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= val_q;
          cycles <= total_q;
          flag_x <= xq;
          flag_c <= cq;
          flag_v <= vq;
          flag_n <= val_q[msb_pos(sz_q)];
          flag_z <= (val_q == '0);
        end
      end
    end
  end
endmodule

// File: rtl/bitstep_shifter_chk.sv
module bitstep_shifter_chk #(
  parameter int CYC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             mem_form,
  input logic [1:0]       op_kind,
  input logic [1:0]       size,
  input logic             x_in,
  input logic             busy,
  input logic             done,
  input logic [CYC_W-1:0] cycles,
  input logic [31:0]      result,
  input logic             flag_x,
  input logic             flag_v
);
  logic             take;
  logic [CYC_W-1:0] cnt;
  logic [1:0]       opk_q, sz_q;
  logic             x_q;

  assign take = start && !busy && !(mem_form && size[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      opk_q <= 2'd0;
      sz_q  <= 2'd0;
      x_q   <= 1'b0;
    end else if (take) begin
      cnt   <= CYC_W'(1);
      opk_q <= op_kind;
      sz_q  <= size;
      x_q   <= x_in;
    end else if (busy) begin
      cnt <= cnt + CYC_W'(1);
    end
  end

  // R1
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == cycles + CYC_W'(1)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  byte_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && sz_q == 2'd0) |-> (result[31:8] == 24'd0));

  // R6
  v_only_arith_chk: assert property (@(posedge clk) disable iff (rst)
    (done && opk_q != 2'd0) |-> !flag_v);

  // R5
  rot_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
    (done && opk_q == 2'd2) |-> (flag_x == x_q));

  // R8
  mem_long_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mem_form && size[1]) |=> !busy);
endmodule

bind bitstep_shifter bitstep_shifter_chk #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_form(mem_form),
  .op_kind(op_kind), .size(size), .x_in(x_in), .busy(busy),
  .done(done), .cycles(cycles), .result(result),
  .flag_x(flag_x), .flag_v(flag_v)
);

// File: tb/bitstep_shifter_bench.sv
`timescale 1ns/100ps
module bitstep_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, mem_form = 1'b0, dir_left = 1'b0, x_in = 1'b0;
  logic [1:0]  op_kind = 2'd0, size = 2'd0;
  logic [31:0] operand = '0;
  logic [5:0]  count = '0;
  logic [31:0] result;
  logic        flag_x, flag_n, flag_z, flag_v, flag_c, done;
  logic [7:0]  cycles;

  int checks = 0, errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitstep_shifter u_bitstep_shifter (
    .clk(clk), .rst(rst), .start(start), .mem_form(mem_form),
    .op_kind(op_kind), .dir_left(dir_left), .size(size), .operand(operand),
    .count(count), .x_in(x_in), .result(result), .flag_x(flag_x),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .done(done), .cycles(cycles)
  );

  typedef struct packed {
    logic [1:0]  opk;
    logic        lft;
    logic [1:0]  sz;
    logic        xi;
    logic [5:0]  n;
    logic [31:0] opd;
    logic [31:0] res;
    logic [4:0]  fl;
    logic [7:0]  cyc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b1, 2'd0, 1'b0, 6'd1,  32'h40,       32'h80,   5'b01010, 8'd8},
    '{2'd1, 1'b0, 2'd1, 1'b0, 6'd1,  32'h8001,     32'h4000, 5'b10001, 8'd8},
    '{2'd0, 1'b0, 2'd0, 1'b0, 6'd3,  32'h80,       32'hF0,   5'b01000, 8'd12},
    '{2'd2, 1'b1, 2'd2, 1'b1, 6'd4,  32'h80000001, 32'h18,   5'b10000, 8'd16},
    '{2'd3, 1'b0, 2'd0, 1'b0, 6'd1,  32'h01,       32'h00,   5'b10101, 8'd8},
    '{2'd3, 1'b1, 2'd1, 1'b1, 6'd0,  32'h0,        32'h0,    5'b10101, 8'd6},
    '{2'd1, 1'b1, 2'd2, 1'b0, 6'd32, 32'h1,        32'h0,    5'b10101, 8'd72},
    '{2'd0, 1'b1, 2'd1, 1'b0, 6'd1,  32'hC000,     32'h8000, 5'b11001, 8'd8}
  };

  function automatic logic [4:0] flags_now();
    return {flag_x, flag_n, flag_z, flag_v, flag_c};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference for R3..R6: bit-serial model over a size-wide lane.
  task automatic ref_model(input int opk, input bit lft, input int sz,
                           input logic [31:0] opd, input int n, input bit xi,
                           output logic [31:0] r, output logic [4:0] f);
    int w;
    logic [31:0] v, mask;
    bit x, c, vf, top, bot, o;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    v = opd & mask; x = xi; c = (opk == 3) ? xi : 1'b0; vf = 1'b0;
    for (int i = 0; i < n; i++) begin
      top = v[w-1]; bot = v[0];
      if (lft) begin
        o = top;
        if (opk == 0 && v[w-1] != v[w-2]) vf = 1'b1;
        v = v << 1;
        if (opk == 2) v[0] = top;
        if (opk == 3) v[0] = x;
      end else begin
        o = bot;
        v = v >> 1;
        if (opk == 0) v[w-1] = top;
        if (opk == 2) v[w-1] = bot;
        if (opk == 3) v[w-1] = x;
      end
      v = v & mask;
      c = o;
      if (opk != 2) x = o;
    end
    r = v;
    f = {x, v[w-1], (v == 0), vf, c};
  endtask

  task automatic launch(input logic [1:0] opk, input logic lft, input logic [1:0] sz,
                        input logic mem, input logic xi, input logic [5:0] n,
                        input logic [31:0] opd, output int t0);
    @(negedge clk);
    start = 1'b1; op_kind = opk; dir_left = lft; size = sz; mem_form = mem;
    x_in = xi; count = n; operand = opd;
    @(posedge clk);
    @(negedge clk);
    t0 = cyc;
    start = 1'b0; mem_form = 1'b0;
  endtask

  task automatic await_done(input int t0, output int lat);
    while (!done && (cyc - t0) < 400) begin
      @(negedge clk);
    end
    lat = cyc - t0;
  endtask

  task automatic run(input logic [1:0] opk, input logic lft, input logic [1:0] sz,
                     input logic mem, input logic xi, input logic [5:0] n,
                     input logic [31:0] opd, output int lat);
    int t0;
    launch(opk, lft, sz, mem, xi, n, opd, t0);
    await_done(t0, lat);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lat, t0, t1;
    logic [31:0] er;
    logic [4:0]  ef;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "done", {31'd0, done}, 32'd0);
    check("R11", "result", result, 32'd0);
    check("R11", "cycles", {24'd0, cycles}, 32'd0);
    check("R11", "flags", {27'd0, flags_now()}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Hand-computed vectors: R1 R2 R3 R4 R5 R6
    foreach (VECS[i]) begin
      run(VECS[i].opk, VECS[i].lft, VECS[i].sz, 1'b0, VECS[i].xi,
          VECS[i].n, VECS[i].opd, lat);
      check("R3/R4", "vector result", result, VECS[i].res);
      check("R5/R6", "vector flags", {27'd0, flags_now()}, {27'd0, VECS[i].fl});
      check("R1", "vector latency", lat, {24'd0, VECS[i].cyc});
      check("R1", "vector cycles", {24'd0, cycles}, {24'd0, VECS[i].cyc});
    end

    // R10: done is a pulse, outputs hold
    er = result;
    @(negedge clk);
    check("R10", "done pulse", {31'd0, done}, 32'd0);
    repeat (5) @(negedge clk);
    check("R10", "result held", result, er);

    // Sweep every size, operation, direction, counts 0..63: R1 R2 R3 R4 R5 R6
    for (int sz = 0; sz < 3; sz++)
      for (int opk = 0; opk < 4; opk++)
        for (int d = 0; d < 2; d++)
          for (int n = 0; n < 64; n++) begin
            logic [31:0] opd;
            bit xi;
            opd = 32'h9E37_79B9 ^ (32'(n) * 32'h0101_0107) ^ (32'(opk) << 9) ^ 32'(d);
            xi  = n[0] ^ d[0];
            ref_model(opk, d[0], sz, opd, n, xi, er, ef);
            run(2'(opk), d[0], 2'(sz), 1'b0, xi, 6'(n), opd, lat);
            check("R3/R4", "sweep result", result, er);
            check("R5/R6", "sweep flags", {27'd0, flags_now()}, {27'd0, ef});
            check("R1", "sweep latency", lat, (sz == 2 ? 8 : 6) + 2 * n);
          end

    // R7 memory form: word, count ignored
    run(2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 6'd37, 32'h8001, lat);
    check("R7", "mem word result", result, 32'h0002);
    check("R7", "mem word flags", {27'd0, flags_now()}, {27'd0, 5'b10011});
    check("R7", "mem word latency", lat, 8);
    check("R7", "mem word cycles", {24'd0, cycles}, 32'd8);
    // R7 memory form: byte, zero count still moves one bit
    run(2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 6'd0, 32'h03, lat);
    check("R7", "mem byte result", result, 32'h01);
    check("R7", "mem byte flags", {27'd0, flags_now()}, {27'd0, 5'b10001});
    check("R7", "mem byte latency", lat, 8);

    // R8 memory form at long size is refused
    er = result; ef = flags_now();
    launch(2'd1, 1'b1, 2'd2, 1'b1, 1'b1, 6'd1, 32'hFFFF_FFFF, t0);
    lat = 0;
    repeat (20) begin
      if (done) lat++;
      @(negedge clk);
    end
    check("R8", "no done for mem long", lat, 0);
    check("R8", "result unchanged", result, er);
    check("R8", "flags unchanged", {27'd0, flags_now()}, {27'd0, ef});

    // R9 start while busy is ignored
    launch(2'd2, 1'b1, 2'd2, 1'b0, 1'b0, 6'd63, 32'h1, t0);
    repeat (10) @(negedge clk);
    launch(2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 6'd0, 32'h55, t1);
    await_done(t0, lat);
    check("R9", "busy start latency", lat, 134);
    check("R9", "busy start result", result, 32'h8000_0000);
    repeat (10) @(negedge clk);
    check("R9", "no second done", {31'd0, done}, 32'd0);
    check("R9", "result kept", result, 32'h8000_0000);

    finish_run();
  end
endmodule